// File: doc/BRIEF.md
# Dual-Mode Watchdog Timer

This block is a 16-bit down-counting timer that can also act as a watchdog. The system clock is divided in two stages: an 8-bit programmable prescaler, then a fixed division factor of 16, 32, 64 or 128. Each resulting tick lowers the live count by one. When the count expires, the counter reloads from a reload register and keeps running. On expiry the block can raise a one-cycle interrupt, which makes it an ordinary interval timer. It can also issue a reset pulse held for exactly 128 clock cycles, which makes it a watchdog. Either action, both, or neither may be enabled.

Software controls the block through a small word-wide register bus with three registers: control, reload value and live counter. To keep the system alive, software writes the live counter before it runs out. That write restarts both the countdown and the divider chain, so the next expiry comes a full programmed interval after the write. The interval from a write of L is L × (prescale + 1) × factor clock cycles.

Top module: `wdog_timer`

## Requirements
- R1: After reset the control register reads 0 (timer stopped, no interrupt, no reset), the reload and live counter registers both read 0x8000, and `irq_o` and `wdt_rst_o` are low.
- R2: The tick period in clock cycles is (P + 1) × (16 << S). P is control bits [15:8] and S is control bits [4:3], so S = 0, 1, 2, 3 selects 16, 32, 64, 128.
- R3: With the run bit (control bit 0) set, after a write of L ≥ 1 to the live counter, expiry occurs exactly L tick periods after the clock edge that took the write.
- R4: On expiry the live counter reloads from the reload register and counting continues, so the next expiry follows after reload-value tick periods.
- R5: On expiry `irq_o` is high for exactly one cycle, starting the cycle after the expiry edge, only if the interrupt enable (control bit 1) is set.
- R6: On expiry `wdt_rst_o` goes high the cycle after the expiry edge and stays high for exactly 128 cycles, only if the reset enable (control bit 2) is set. A new expiry during the pulse restarts the full width.
- R7: While the run bit is 0 the live counter holds its value and neither output is asserted.
- R8: A write to the live counter overrides a tick in the same cycle and restarts the divider chain. Writing again before expiry therefore prevents any interrupt or reset.
- R9: Reads use the address map 0 = control, 1 = reload, 2 = live counter, 3 = zero. `bus_rdata` is registered, so it shows the register addressed at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq_o | output | 1 | One-cycle expiry interrupt |
| wdt_rst_o | output | 1 | 128-cycle watchdog reset pulse |

## Verification
The bound checker watches, on every cycle:
- that each interrupt lasts a single cycle and each reset pulse lasts exactly 128 cycles, each appearing only when its enable was set;
- that a stopped timer's counter stays frozen;
- that a counter write always lands.

Only the bench scenarios can show:
- the absolute expiry timing as a function of prescale, factor and load value;
- the reload interval;
- that periodic servicing fully suppresses both outputs.

The bench covers these with randomly drawn settings compared against a computed period.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_RLD   = 2'd1,
    REG_COUNT = 2'd2,
    REG_NONE  = 2'd3
  } reg_sel_e;

  localparam int BIT_RUN    = 0;
  localparam int BIT_IRQ_EN = 1;
  localparam int BIT_RST_EN = 2;
  localparam int SEL_LSB    = 3;
endpackage

// File: rtl/wdt_divider.sv
module wdt_divider #(
  parameter int PRE_W    = 8,
  parameter int DIV_BASE = 16,
  parameter int SEL_W    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [PRE_W-1:0] pre,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int DIV_W = $clog2(DIV_BASE) + (1 << SEL_W) - 1;

  logic [PRE_W-1:0] pre_cnt;
  logic [DIV_W-1:0] div_cnt;
  logic [DIV_W-1:0] div_lim;
  logic             pre_wrap;
  logic             div_wrap;

  assign div_lim  = DIV_W'((DIV_BASE << sel) - 1);
  assign pre_wrap = (pre_cnt >= pre);
  assign div_wrap = (div_cnt >= div_lim);
  assign tick     = run && !restart && pre_wrap && div_wrap;

  always_ff @(posedge clk) begin
    if (rst || !run || restart) begin
      pre_cnt <= '0;
      div_cnt <= '0;
    end else if (pre_wrap) begin
      pre_cnt <= '0;
      div_cnt <= div_wrap ? '0 : div_cnt + 1'b1;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int          CNT_W    = 16,
  parameter logic [15:0] CNT_INIT = 16'h8000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load_we,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  assign expire = tick && !load_we && (cnt <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst)          cnt <= CNT_W'(CNT_INIT);
    else if (load_we) cnt <= load_val;
    else if (expire)  cnt <= reload_val;
    else if (tick)    cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/wdt_stretch.sv
module wdt_stretch #(
  parameter int WIDTH = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic pulse
);
  localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;

  logic [CW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      left  <= '0;
      pulse <= 1'b0;
    end else if (trig) begin
      left  <= CW'(WIDTH - 1);
      pulse <= 1'b1;
    end else begin
      pulse <= (left != '0);
      if (left != '0) left <= left - 1'b1;
    end
  end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int          CNT_W      = 16,
  parameter int          PRE_W      = 8,
  parameter int          DIV_BASE   = 16,
  parameter int          SEL_W      = 2,
  parameter int          RST_CYCLES = 128,
  parameter logic [15:0] CNT_INIT   = 16'h8000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_we,
  input  logic [1:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic             irq_o,
  output logic             wdt_rst_o
);
  import wdt_pkg::*;

  logic [CNT_W-1:0] ctrl_q;
  logic [CNT_W-1:0] rld_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tick;
  logic             expire;
  logic             cnt_we;
  logic             run;
  logic             irq_en;
  logic             rst_en;
  reg_sel_e         sel_addr;

  assign sel_addr = reg_sel_e'(bus_addr);
  assign cnt_we   = bus_we && (sel_addr == REG_COUNT);
  assign run      = ctrl_q[BIT_RUN];
  assign irq_en   = ctrl_q[BIT_IRQ_EN];
  assign rst_en   = ctrl_q[BIT_RST_EN];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      rld_q  <= CNT_W'(CNT_INIT);
    end else if (bus_we) begin
      if (sel_addr == REG_CTRL) ctrl_q <= bus_wdata;
      if (sel_addr == REG_RLD)  rld_q  <= bus_wdata;
    end
  end

  wdt_divider #(.PRE_W(PRE_W), .DIV_BASE(DIV_BASE), .SEL_W(SEL_W)) u_div (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .restart (cnt_we),
    .pre     (ctrl_q[CNT_W-1 -: PRE_W]),
    .sel     (ctrl_q[SEL_LSB +: SEL_W]),
    .tick    (tick)
  );

  wdt_countdown #(.CNT_W(CNT_W), .CNT_INIT(CNT_INIT)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .load_we    (cnt_we),
    .load_val   (bus_wdata),
    .reload_val (rld_q),
    .cnt        (cnt_q),
    .expire     (expire)
  );

  wdt_stretch #(.WIDTH(RST_CYCLES)) u_pulse (
    .clk   (clk),
    .rst   (rst),
    .trig  (expire && rst_en),
    .pulse (wdt_rst_o)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= expire && irq_en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (sel_addr)
        REG_CTRL:  bus_rdata <= ctrl_q;
        REG_RLD:   bus_rdata <= rld_q;
        REG_COUNT: bus_rdata <= cnt_q;
        default:   bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int CNT_W      = 16,
  parameter int RST_CYCLES = 128
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_we,
  input logic [1:0]       bus_addr,
  input logic [CNT_W-1:0] bus_wdata,
  input logic             irq_o,
  input logic             wdt_rst_o,
  input logic [CNT_W-1:0] ctrl_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             expire
);
  localparam int HW = $clog2(RST_CYCLES) + 2;

  logic          trig_q;
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_q <= 1'b0;
      hi_cnt <= '0;
    end else begin
      trig_q <= expire && ctrl_q[2];
      if (!wdt_rst_o)  hi_cnt <= '0;
      else if (trig_q) hi_cnt <= HW'(1);
      else             hi_cnt <= hi_cnt + 1'b1;
    end
  end

  // R5: interrupt is a single-cycle pulse
  p_irq_single_r5: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o);

  // R5: interrupt only when enabled at expiry
  p_irq_enable_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past(ctrl_q[1]));

  // R6: reset pulse only when enabled at expiry
  p_rst_enable_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(wdt_rst_o) |-> $past(ctrl_q[2]));

  // R6: pulse ends after exactly the programmed width
  p_rst_width_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(wdt_rst_o) |-> (hi_cnt == HW'(RST_CYCLES)));

  // R6: pulse never exceeds the width
  p_rst_max_r6: assert property (@(posedge clk) disable iff (rst)
    hi_cnt <= HW'(RST_CYCLES));

  // R7: stopped timer holds its count
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q[0] && !(bus_we && bus_addr == 2'd2)) |=> $stable(cnt_q));

  // R8: counter write always takes effect
  p_write_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == 2'd2) |=> (cnt_q == $past(bus_wdata)));
endmodule

bind wdog_timer wdt_checker #(.CNT_W(CNT_W), .RST_CYCLES(RST_CYCLES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .irq_o     (irq_o),
  .wdt_rst_o (wdt_rst_o),
  .ctrl_q    (ctrl_q),
  .cnt_q     (cnt_q),
  .expire    (expire)
);

// File: tb/test_wdog_timer.sv
module test_wdog_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic        irq_o;
  logic        wdt_rst_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  wdog_timer i_wdog_timer (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .wdt_rst_o(wdt_rst_o)
  );

  function automatic int period(int pre, int sel);
    return (pre + 1) * (16 << sel);
  endfunction

  function automatic logic [15:0] ctrl_word(int pre, int sel, bit re, bit ie, bit run);
    return {pre[7:0], 3'b000, sel[1:0], re, ie, run};
  endfunction

  task automatic check(string tag, int got, int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output int v);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    v = int'(bus_rdata);
  endtask

  task automatic observe(int n, output int i_first, output int i_last,
                         output int i_cnt, output int r_first, output int r_cnt);
    i_first = -1; i_last = -1; i_cnt = 0; r_first = -1; r_cnt = 0;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      if (irq_o) begin
        if (i_cnt == 0) i_first = k;
        i_last = k;
        i_cnt++;
      end
      if (wdt_rst_o) begin
        if (r_cnt == 0) r_first = k;
        r_cnt++;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    int v, i_first, i_last, i_cnt, r_first, r_cnt;
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state, R9 address map
    check("R1 irq", int'(irq_o), 0);
    check("R1 rst_out", int'(wdt_rst_o), 0);
    rd(2'd0, v); check("R1 ctrl", v, 0);
    rd(2'd1, v); check("R1 reload", v, 32'h8000);
    rd(2'd2, v); check("R1 counter", v, 32'h8000);
    rd(2'd3, v); check("R9 unused addr", v, 0);

    // R7: stopped timer holds, no outputs
    wr(2'd0, ctrl_word(0, 0, 1'b1, 1'b1, 1'b0));
    wr(2'd2, 16'd2);
    observe(300, i_first, i_last, i_cnt, r_first, r_cnt);
    check("R7 irq while stopped", i_cnt, 0);
    check("R7 reset while stopped", r_cnt, 0);
    rd(2'd2, v); check("R7 counter held", v, 2);
    rd(2'd0, v); check("R9 ctrl readback", v, int'(ctrl_word(0, 0, 1'b1, 1'b1, 1'b0)));

    // R4: reload 3, load 2, period 16 -> expiries at 32 and 80
    wr(2'd1, 16'd3);
    rd(2'd1, v); check("R9 reload readback", v, 3);
    wr(2'd0, ctrl_word(0, 0, 1'b0, 1'b1, 1'b1));
    wr(2'd2, 16'd2);
    observe(90, i_first, i_last, i_cnt, r_first, r_cnt);
    check("R3 first expiry", i_first, 32);
    check("R4 reload expiry", i_last, 80);
    check("R4 irq count", i_cnt, 2);
    check("R6 no reset when disabled", r_cnt, 0);

    // R8: servicing prevents expiry
    wr(2'd0, ctrl_word(0, 0, 1'b1, 1'b1, 1'b1));
    for (int s = 0; s < 6; s++) begin
      wr(2'd2, 16'd4);
      observe(40, i_first, i_last, i_cnt, r_first, r_cnt);
      check("R8 serviced irq", i_cnt, 0);
      check("R8 serviced reset", r_cnt, 0);
    end
    wr(2'd0, 16'd0);
    repeat (140) @(negedge clk);

    // R2 R3 R5 R6: random settings
    wr(2'd1, 16'd1000);
    for (int it = 0; it < 14; it++) begin
      int pre, sel, ld, p;
      bit ie, re;
      pre = int'($urandom % 4);
      sel = int'($urandom % 4);
      ld  = 1 + int'($urandom % 5);
      ie  = bit'($urandom % 2);
      re  = bit'($urandom % 2);
      p   = period(pre, sel);
      wr(2'd0, 16'd0);
      wr(2'd0, ctrl_word(pre, sel, re, ie, 1'b1));
      wr(2'd2, ld[15:0]);
      observe(ld * p + 130, i_first, i_last, i_cnt, r_first, r_cnt);
      check("R2 R3 irq timing", i_first, ie ? ld * p : -1);
      check("R5 irq width", i_cnt, ie ? 1 : 0);
      check("R6 reset start", r_first, re ? ld * p : -1);
      check("R6 reset width", r_cnt, re ? 128 : 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule